// File: doc/BRIEF.md
# PLL Reconfiguration Recovery Sequencer

This block oversees the end of a PLL scan-chain reload and repairs a known fault: after the last configuration bit has been shifted in, the PLL's scan data output can stay high. Feedback and pre-divider counter updates are not applied until that output has been driven low again. Software or a loader state machine pulses a start strobe when it begins a reload. The sequencer then waits for the scan output to go high. After that it holds off for a settle interval, pulses the PLL's asynchronous reset for a guaranteed minimum width, and confirms that the scan output has dropped.

The settle interval comes from a requested cycle count. That count is the largest post-scale divider over 0.8 times the VCO rate, converted to system-clock cycles. It is capped at the cycle count that equals 2 µs. The reset width is never shorter than the cycle count that equals 500 ns. The block raises its own busy flag for the whole recovery and lowers it only once the scan output is seen low, so anything that follows the PLL's internal busy line gets a clean indication. A one-cycle done pulse marks success. A sticky error flag marks a scan output that never falls.

Top module: `pllcfg_recover`

## Requirements
- R1: While and right after synchronous reset, `pll_areset`, `busy`, `done` and `err` are all 0.
- R2: A `cfg_start` pulse seen while idle makes `busy` 1 on the next cycle. The block then waits for `scan_out` to go high for as long as needed, with `pll_areset` held at 0. `busy` only ever rises on the cycle after `cfg_start` was 1.
- R3: With S = min(`SETTLE_REQ_CYC`, 2·`CLK_MHZ`) (at least 1), `pll_areset` rises on the (S+3)-th rising clock edge, counting the first edge that samples `scan_out` high as edge 1. The 3 extra edges are two synchronizer stages plus one state register. With the defaults, S = 250.
- R4: `pll_areset` stays high for exactly R = max(`RST_REQ_CYC`, ceil(`CLK_MHZ`·500/1000)) cycles. With the defaults, R = 63.
- R5: `busy` stays 1 from acceptance of the start until `done` pulses. `done` is high for exactly one cycle, and in that cycle `busy` and `pll_areset` are 0.
- R6: Count the edges after `pll_areset` falls as 1, 2, … . If `scan_out` is driven low before edge d+1, then `done` rises on edge d+3. This holds for every d up to `CHECK_CYC`−3, including the case where a low `scan_out` is recognised on the same edge as the check window closes.
- R7: If the synchronized `scan_out` is still high on edge `CHECK_CYC` after `pll_areset` falls, then `err` becomes 1 on that edge, `busy` drops, the block returns to idle, and `done` does not pulse.
- R8: `cfg_start` is ignored in every state except idle. A start pulse during the settle or reset phase leaves the timing of R3, R4 and R6 unchanged, and `busy` is 0 on the cycle after `done`.
- R9: `err` stays set while the block is idle. It clears on the cycle after the next accepted `cfg_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle strobe marking the start of a scan-chain reload |
| scan_out | input | 1 | PLL scan data output, asynchronous to `clk` |
| pll_areset | output | 1 | Asynchronous reset driven to the PLL |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse: scan output confirmed low |
| err | output | 1 | Sticky: scan output stayed high after the reset |

## Verification
A falling scan output and the close of the post-reset check window can land on the same clock edge. The block must then report success, not an error. The bench drives the fall so that the synchronized low arrives exactly on the last check edge (d = `CHECK_CYC`−3) and expects `done` with `err` still 0. It repeats the case one cycle later and expects `err`, with no `done`. A second overlap is a start strobe arriving while a recovery is running. This is provoked during the settle and reset phases and judged by unchanged reset latency and width and by `busy` staying low after `done`.

// File: rtl/pllcfg_recover_pkg.sv
package pllcfg_recover_pkg;

    typedef enum logic [2:0] {
        IDLE,
        WAIT_HIGH,
        SETTLE,
        RESET,
        CHECK_LOW,
        DONE
    } seq_state_e;

    typedef struct packed {
        logic areset;
        logic busy;
        logic done;
    } seq_out_t;

    localparam int SETTLE_CAP_NS = 2000;
    localparam int RESET_MIN_NS  = 500;

    function automatic int settle_cycles(int req, int mhz);
        int cap;
        int v;
        cap = (mhz * SETTLE_CAP_NS) / 1000;
        v   = (req < cap) ? req : cap;
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int reset_cycles(int req, int mhz);
        int lo;
        lo = (mhz * RESET_MIN_NS + 999) / 1000;
        if (lo < 1) lo = 1;
        return (req > lo) ? req : lo;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/prr_sync.sv
module prr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/prr_countdown.sv
module prr_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/prr_seq_ctrl.sv
module prr_seq_ctrl
    import pllcfg_recover_pkg::*;
#(
    parameter int W          = 8,
    parameter int SETTLE_EFF = 4,
    parameter int RESET_EFF  = 4,
    parameter int CHECK_EFF  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sdo_s,
    input  logic         tmr_zero,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output seq_out_t     outs,
    output logic         err
);
    seq_state_e st, nxt;
    logic       set_err;
    logic       take_start;

    assign take_start = (st == IDLE) && start;

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        set_err  = 1'b0;
        unique case (st)
            IDLE: if (start) nxt = WAIT_HIGH;
            WAIT_HIGH: if (sdo_s) begin
                nxt      = SETTLE;
                tmr_load = 1'b1;
                tmr_val  = W'(SETTLE_EFF - 1);
            end
            SETTLE: if (tmr_zero) begin
                nxt      = RESET;
                tmr_load = 1'b1;
                tmr_val  = W'(RESET_EFF - 1);
            end
            RESET: if (tmr_zero) begin
                nxt      = CHECK_LOW;
                tmr_load = 1'b1;
                tmr_val  = W'(CHECK_EFF - 1);
            end
            CHECK_LOW: begin
                // a low scan output wins over an expiring window
                if (!sdo_s) nxt = DONE;
                else if (tmr_zero) begin
                    nxt     = IDLE;
                    set_err = 1'b1;
                end
            end
            DONE: nxt = IDLE;
            default: nxt = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= IDLE;
            outs <= '0;
            err  <= 1'b0;
        end else begin
            st          <= nxt;
            outs.areset <= (nxt == RESET);
            outs.busy   <= (nxt == WAIT_HIGH) || (nxt == SETTLE) ||
                           (nxt == RESET) || (nxt == CHECK_LOW);
            outs.done   <= (nxt == DONE);
            if (take_start)   err <= 1'b0;
            else if (set_err) err <= 1'b1;
        end
    end
endmodule

// File: rtl/pllcfg_recover.sv
module pllcfg_recover
    import pllcfg_recover_pkg::*;
#(
    parameter int CLK_MHZ        = 125,
    parameter int SETTLE_REQ_CYC = 300,
    parameter int RST_REQ_CYC    = 0,
    parameter int CHECK_CYC      = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_start,
    input  logic scan_out,
    output logic pll_areset,
    output logic busy,
    output logic done,
    output logic err
);
    localparam int SETTLE_EFF = settle_cycles(SETTLE_REQ_CYC, CLK_MHZ);
    localparam int RESET_EFF  = reset_cycles(RST_REQ_CYC, CLK_MHZ);
    localparam int CHECK_EFF  = (CHECK_CYC < 1) ? 1 : CHECK_CYC;
    localparam int LONGEST    = max3(SETTLE_EFF, RESET_EFF, CHECK_EFF);
    localparam int CNT_W      = $clog2(LONGEST + 1);

    logic             sdo_s;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    seq_out_t         outs;

    prr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scan_out),
        .q   (sdo_s)
    );

    prr_countdown #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prr_seq_ctrl #(
        .W          (CNT_W),
        .SETTLE_EFF (SETTLE_EFF),
        .RESET_EFF  (RESET_EFF),
        .CHECK_EFF  (CHECK_EFF)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (cfg_start),
        .sdo_s    (sdo_s),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .outs     (outs),
        .err      (err)
    );

    assign pll_areset = outs.areset;
    assign busy       = outs.busy;
    assign done       = outs.done;
endmodule

// File: rtl/pllcfg_recover_chk.sv
module pllcfg_recover_chk
    import pllcfg_recover_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int RST_REQ_CYC = 0
) (
    input logic clk,
    input logic rst,
    input logic cfg_start,
    input logic pll_areset,
    input logic busy,
    input logic done,
    input logic err
);
    localparam int RW = reset_cycles(RST_REQ_CYC, CLK_MHZ);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= '0;
        else if (pll_areset) run_len <= run_len + 16'd1;
        else                 run_len <= '0;
    end

    assert_areset_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
        pll_areset |-> busy);

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_start));

    assert_areset_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_areset) |-> (run_len == 16'(RW)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !pll_areset));

    assert_err_no_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (!done && !busy));
endmodule

bind pllcfg_recover pllcfg_recover_chk #(
    .CLK_MHZ     (CLK_MHZ),
    .RST_REQ_CYC (RST_REQ_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_start  (cfg_start),
    .pll_areset (pll_areset),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/pllcfg_recover_test.sv
`timescale 1ns/1ps
module pllcfg_recover_test;
    localparam int EXP_S = 250;  // min(300, 2*125)
    localparam int EXP_R = 63;   // ceil(125*500/1000)
    localparam int EXP_C = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_start = 1'b0;
    logic scan_out = 1'b0;
    logic pll_areset, busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pllcfg_recover uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_start  (cfg_start),
        .scan_out   (scan_out),
        .pll_areset (pll_areset),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic checkv(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_start = 1'b0; scan_out = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic pulse_start();
        cfg_start = 1'b1;
        tick();
        cfg_start = 1'b0;
    endtask

    // start, PLL stub raises scan_out, measure latency and reset width
    task automatic lead_in(bit poke);
        int n;
        int w;
        pulse_start();
        checkv("R2 busy after start", busy, 1);
        repeat (10) tick();
        checkv("R2 waiting busy", busy, 1);
        checkv("R2 no reset while waiting", pll_areset, 0);
        scan_out = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
            if (poke && n == 5) cfg_start = 1'b1;   // R8 poke in settle
            if (poke && n == 6) cfg_start = 1'b0;
        end while (!pll_areset && n < 1000);
        checkv(poke ? "R8 R3 latency" : "R3 latency", n, EXP_S + 3);
        w = 1;
        while (w < 2000) begin
            if (poke && w == 10) cfg_start = 1'b1;  // R8 poke in reset
            tick();
            cfg_start = 1'b0;
            if (!pll_areset) break;
            w++;
        end
        checkv(poke ? "R8 R4 width" : "R4 width", w, EXP_R);
        checkv("R5 busy after reset", busy, 1);
    endtask

    // d: negedge (after reset fall) at which the stub drops scan_out; -1 never
    task automatic t_seq(int d, bit poke);
        int m;
        int busy_gaps;
        bit ok;
        ok = (d >= 0) && (d <= EXP_C - 3);
        lead_in(poke);
        m = 0;
        busy_gaps = 0;
        if (d == 0) scan_out = 1'b0;
        while (m < 50) begin
            tick();
            m++;
            if (m == d) scan_out = 1'b0;
            if (done || err) break;
            if (!busy) busy_gaps++;
        end
        checkv("R5 busy held until low", busy_gaps, 0);
        if (ok) begin
            checkv("R6 done cycle", m, d + 3);
            checkv("R6 done high", done, 1);
            checkv("R6 no error", err, 0);
            checkv("R5 busy low at done", busy, 0);
            tick();
            checkv("R5 done one cycle", done, 0);
            checkv("R8 still idle after done", busy, 0);
        end else begin
            checkv("R7 error cycle", m, EXP_C);
            checkv("R7 error set", err, 1);
            checkv("R7 no done", done, 0);
            checkv("R7 busy dropped", busy, 0);
            tick();
            checkv("R7 no late done", done, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tick();
        checkv("R1 areset in reset", pll_areset, 0);
        checkv("R1 busy in reset", busy, 0);
        do_reset();
        checkv("R1 areset", pll_areset, 0);
        checkv("R1 busy", busy, 0);
        checkv("R1 done", done, 0);
        checkv("R1 err", err, 0);

        t_seq(0, 0);
        t_seq(2, 0);
        t_seq(EXP_C - 3, 0);   // R6 low seen on last window edge
        t_seq(EXP_C - 2, 0);   // R7 one cycle too late

        repeat (5) tick();
        checkv("R9 err sticky while idle", err, 1);
        scan_out = 1'b0;
        pulse_start();
        checkv("R9 err cleared on start", err, 0);
        checkv("R9 busy on start", busy, 1);
        do_reset();

        t_seq(-1, 0);          // R7 stuck high
        do_reset();
        t_seq(1, 1);           // R8 start pokes ignored

        finish_run();
    end
endmodule